// File: doc/BRIEF.md
# Aligned PWM Channel Generator

This block produces one pulse-width-modulated output from an 8-bit period setting and an 8-bit duty setting. A counter advances once per channel clock tick, which is a single-cycle enable supplied from outside. In left mode the counter ramps up and wraps. In center mode it ramps up and then back down, so the pulse sits symmetrically about the peak. A comparator decides whether the counter is still inside the duty phase. A polarity input chooses the level driven during that phase. The output is registered, so it cannot glitch.

Software writes the period, duty and counter through a small register-style port, and a read port returns the live count. The period and duty writes land in buffer registers. They are copied to the working registers only when a period ends, when the counter is restarted, or while the channel is disabled. The waveform therefore changes only on whole-period boundaries. Writing the counter restarts the period at once.

Top module: `pwm_align_chan`

## Requirements
- R1: In left mode (center_mode=0) with PER>0 and tick high every cycle, the counter steps 0,1,…,PER−1 and then returns to 0, so the output repeats every PER ticks.
- R2: In center mode (center_mode=1) with PER>0, the counter steps up from 0 to PER−1 and then down to 0, holding each end value for two ticks, so the output repeats every 2×PER ticks (PER=3 gives 0,1,2,2,1,0,0,1,…).
- R3: The output is in the duty phase while count < DTY. With pol_start_high=1 the duty phase is high, which gives DTY high ticks per PER in left mode and 2×DTY per 2×PER in center mode. With pol_start_high=0 the output is inverted.
- R4: DTY ≥ PER (with PER>0) holds the output at the duty-phase level for the whole period. PER=0 keeps the count at 0 and the output constant: the duty-phase level if DTY>0, the other level if DTY=0.
- R5: A write with wr_sel=2 forces the count to 0 and the direction to up, restarts the period, and moves the buffered period and duty into use.
- R6: A write with wr_sel=0 (period) or wr_sel=1 (duty) goes to a buffer. It takes effect only at the end of the running period, on a counter restart, or while the channel is disabled.
- R7: While chan_en=0 the count stays at 0, and one clock later the output is at the non-duty level, which is the inverse of pol_start_high.
- R8: The count changes only in cycles where tick=1, apart from a restart or disable. pwm_out is registered from the current state, with one clock of latency.
- R9: Synchronous reset clears the count, the buffers and the working registers, and drives pwm_out to 0.
- R10: cnt_q always shows the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Channel clock enable, one cycle per count step |
| chan_en | input | 1 | Channel enable |
| center_mode | input | 1 | 1 selects up/down counting, 0 selects wrap-around |
| pol_start_high | input | 1 | Output level during the duty phase |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 period, 1 duty, 2 counter restart |
| wr_data | input | 8 | Write data |
| cnt_q | output | 8 | Current counter value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A counter that runs past its limit or turns at the wrong point shows up on cnt_q within the same period. It also shows on pwm_out one clock later, as a wrong high count in a period-length window or as a waveform that does not repeat after exactly PER or 2×PER ticks. A buffer that loads too early is visible as a counter peak below the old period before the first wrap. A lost restart is visible as a nonzero count on the first read after the write. A tick-gating fault moves the count during cycles with tick low.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;

    localparam int unsigned PWM_W = 8;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    function automatic logic level_of(input logic duty_phase, input logic pol);
        return duty_phase ? pol : ~pol;
    endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  wr_sel_e      wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] per_act,
    output logic [W-1:0] dty_act
);
    typedef struct packed {
        logic [W-1:0] per;
        logic [W-1:0] dty;
    } pd_t;

    pd_t buf_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_PERIOD) buf_q.per <= wr_data;
            if (wr_en && wr_sel == SEL_DUTY)   buf_q.dty <= wr_data;
            if (load) act_q <= buf_q;
        end
    end

    assign per_act = act_q.per;
    assign dty_act = act_q.dty;

    // R6: working values change only on a load cycle
    assert_hold_between_loads_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> (per_act == $past(per_act) && dty_act == $past(dty_act)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         chan_en,
    input  logic         center,
    input  logic         cnt_wr,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt,
    output logic         load
);
    cnt_dir_e     dir_q;
    logic [W-1:0] cnt_q;
    logic         at_top;
    logic         period_end;

    always_comb begin
        at_top     = (per_act != '0) && (cnt_q >= per_act - W'(1));
        period_end = tick && ((per_act == '0) ||
                              (!center && at_top) ||
                              (center && dir_q == DIR_DOWN && cnt_q == '0));
        load       = !chan_en || cnt_wr || period_end;
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_en || cnt_wr) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (tick) begin
            if (per_act == '0) begin
                cnt_q <= '0;
                dir_q <= DIR_UP;
            end else if (!center) begin
                cnt_q <= at_top ? '0 : cnt_q + W'(1);
                dir_q <= DIR_UP;
            end else if (dir_q == DIR_UP) begin
                if (at_top) dir_q <= DIR_DOWN;
                else        cnt_q <= cnt_q + W'(1);
            end else begin
                if (cnt_q == '0) dir_q <= DIR_UP;
                else             cnt_q <= cnt_q - W'(1);
            end
        end
    end

    assign cnt = cnt_q;

    // R1: count stays inside the active period
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        (per_act != '0) |-> (cnt_q < per_act));
    // R4: zero period keeps the count at zero
    assert_zero_period_R4: assert property (@(posedge clk) disable iff (rst)
        (per_act == '0) |-> (cnt_q == '0));
    // R5: restart clears the count
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == '0));
    // R7: disabled channel parks at zero
    assert_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (cnt_q == '0));
    // R8: no movement without a tick
    assert_tick_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !tick && !cnt_wr) |=> $stable(cnt_q));
    // R2: center counting moves one step at most
    assert_center_step_R2: assert property (@(posedge clk) disable iff (rst)
        (chan_en && center && !cnt_wr) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1) ||
             cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/pwm_level.sv
module pwm_level
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chan_en,
    input  logic         pol,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per_act,
    input  logic [W-1:0] dty_act,
    output logic         pwm_q
);
    logic in_duty;

    assign in_duty = chan_en && (cnt < dty_act);

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= level_of(in_duty, pol);
    end

    // R4: duty at or above the period holds the duty level
    assert_full_duty_R4: assert property (@(posedge clk) disable iff (rst)
        (chan_en && per_act != '0 && dty_act >= per_act) |=> (pwm_q == $past(pol)));
    // R7: disabled channel drives the non-duty level
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (pwm_q != $past(pol)));
endmodule

// File: rtl/pwm_align_chan.sv
module pwm_align_chan
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         chan_en,
    input  logic         center_mode,
    input  logic         pol_start_high,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic         pwm_out
);
    wr_sel_e      sel;
    logic         cnt_wr;
    logic         load;
    logic [W-1:0] per_act;
    logic [W-1:0] dty_act;
    logic [W-1:0] cnt;

    assign sel    = wr_sel_e'(wr_sel);
    assign cnt_wr = wr_en && (sel == SEL_COUNT);

    pwm_shadow_regs #(.W(W)) shadow_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
        .load(load), .per_act(per_act), .dty_act(dty_act)
    );

    pwm_counter #(.W(W)) counter_i (
        .clk(clk), .rst(rst), .tick(tick), .chan_en(chan_en), .center(center_mode),
        .cnt_wr(cnt_wr), .per_act(per_act), .cnt(cnt), .load(load)
    );

    pwm_level #(.W(W)) level_i (
        .clk(clk), .rst(rst), .chan_en(chan_en), .pol(pol_start_high), .cnt(cnt),
        .per_act(per_act), .dty_act(dty_act), .pwm_q(pwm_out)
    );

    assign cnt_q = cnt;
endmodule

// File: tb/pwm_align_chan_tb_top.sv
module pwm_align_chan_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, chan_en = 1'b0, center_mode = 1'b0, pol_start_high = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_q;
    logic       pwm_out;

    int checks = 0, failures = 0;
    logic samp [0:1023];

    always #5 clk = ~clk;

    pwm_align_chan dut_i (
        .clk(clk), .rst(rst), .tick(tick), .chan_en(chan_en), .center_mode(center_mode),
        .pol_start_high(pol_start_high), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_q(cnt_q), .pwm_out(pwm_out)
    );

    // {center, pol, per, dty}
    localparam logic [17:0] VEC [10] = '{
        {1'b0, 1'b1, 8'd10,  8'd3},
        {1'b0, 1'b0, 8'd10,  8'd3},
        {1'b1, 1'b1, 8'd6,   8'd2},
        {1'b1, 1'b0, 8'd6,   8'd2},
        {1'b0, 1'b1, 8'd5,   8'd9},
        {1'b0, 1'b1, 8'd4,   8'd0},
        {1'b0, 1'b1, 8'd0,   8'd4},
        {1'b1, 1'b1, 8'd1,   8'd1},
        {1'b0, 1'b1, 8'd255, 8'd128},
        {1'b1, 1'b0, 8'd0,   8'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic setup(input logic c, input logic p, input logic [7:0] per, input logic [7:0] dty);
        @(negedge clk); chan_en = 1'b0; center_mode = c; pol_start_high = p;
        wr(2'd0, per);
        wr(2'd1, dty);
        repeat (2) @(negedge clk);
        chan_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cnt_q == 8'd0, "R9 reset count", cnt_q, 0);
        chk(pwm_out == 1'b0, "R9 reset output", pwm_out, 0);
        rst = 1'b0;
        tick = 1'b1;

        // R7: disabled with pol 0 rests high, count at 0
        pol_start_high = 1'b0;
        repeat (3) @(negedge clk);
        chk(pwm_out == 1'b1, "R7 idle level pol0", pwm_out, 1);
        chk(cnt_q == 8'd0, "R7 idle count", cnt_q, 0);

        // Table: R1 R2 R3 R4 waveform checks
        for (int v = 0; v < 10; v++) begin
            logic c, p;
            int per, dty, pw, h1, exp_hi, hi, bad;
            {c, p} = VEC[v][17:16];
            per = VEC[v][15:8];
            dty = VEC[v][7:0];
            setup(c, p, per[7:0], dty[7:0]);
            repeat (4) @(negedge clk);
            pw = (per == 0) ? 1 : (c ? 2 * per : per);
            if (per == 0) h1 = (dty != 0) ? 1 : 0;
            else          h1 = (c ? 2 : 1) * ((dty < per) ? dty : per);
            exp_hi = p ? h1 : pw - h1;
            hi = 0; bad = 0;
            for (int i = 0; i < 2 * pw; i++) begin
                @(negedge clk);
                samp[i] = pwm_out;
                if (per == 0 && cnt_q != 8'd0) bad++;
            end
            for (int i = 0; i < pw; i++) begin
                if (samp[i]) hi++;
                if (samp[i] != samp[i + pw]) bad++;
            end
            chk(hi == exp_hi, $sformatf("R3 high count vec%0d (R1/R2 window)", v), hi, exp_hi);
            chk(bad == 0, $sformatf("R1 R2 R4 periodicity vec%0d", v), bad, 0);
        end

        // R8: tick gating
        setup(1'b0, 1'b1, 8'd20, 8'd5);
        repeat (5) @(negedge clk);
        tick = 1'b0;
        begin
            int c0;
            c0 = cnt_q;
            repeat (5) @(negedge clk);
            chk(cnt_q == c0, "R8 hold without tick", cnt_q, c0);
            tick = 1'b1;
            @(negedge clk);
            chk(cnt_q == c0 + 1, "R8 step on tick", cnt_q, c0 + 1);
        end

        // R5 R10: counter restart and readback
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'd77;
        @(negedge clk);
        chk(cnt_q == 8'd0, "R5 restart clears count", cnt_q, 0);
        wr_en = 1'b0; wr_sel = 2'd3;
        repeat (3) @(negedge clk);
        chk(cnt_q == 8'd3, "R10 count readback", cnt_q, 3);

        // R6: period write takes effect only after the running period
        wr(2'd0, 8'd8);
        begin
            bit seen; int mx;
            seen = 1'b0; mx = 0;
            for (int i = 0; i < 30 && !seen; i++) begin
                @(negedge clk);
                if (cnt_q == 8'd19) seen = 1'b1;
            end
            chk(seen, "R6 old period kept", seen, 1);
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (cnt_q > mx) mx = cnt_q;
            end
            chk(mx == 7, "R6 new period after wrap", mx, 7);
        end

        // R2: center sequence for PER=3
        setup(1'b1, 1'b1, 8'd3, 8'd1);
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2;
        begin
            int expv [8] = '{0, 1, 2, 2, 1, 0, 0, 1};
            int bad;
            bad = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                wr_en = 1'b0; wr_sel = 2'd3;
                if (cnt_q != expv[i][7:0]) bad++;
            end
            chk(bad == 0, "R2 center count sequence", bad, 0);
        end

        // R7: disable while running with pol 1
        @(negedge clk); chan_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(pwm_out == 1'b0 && cnt_q == 8'd0, "R7 disable mid-run", pwm_out, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule